// File: doc/BRIEF.md
# Dual-Slot Typed Accumulator Register File

This block holds the architectural registers of a two-wide, slot-paired datapath. It has eight 16-bit registers, and each one carries a one-bit type tag that marks its contents as integer or floating point. Each of the two instruction slots owns an implied accumulator. Slot 0 always works on register 0, and slot 1 always works on register 1. Every slot also names one further register as its operand.

The read side is combinational. Each slot gets one read port for its accumulator and one for its named operand. The write side applies the tag rules of the move, load, accumulate, compare and convert operations. Each slot presents an already-decoded operation class, a write enable, and, where the operation needs one, an externally computed result with a tag. Both slots commit on the same rising edge. Reads always see the state from before that edge, so the two slots in one word behave as if they executed at the same time.

Every pin is a plain control or data pin. There is no handshake: one instruction word is presented per cycle, and the block can never stall.

Top module: `twin_acc_regfile`

## Requirements
- R1: A synchronous, active-high reset clears all eight 16-bit registers to zero and sets every tag to int. The tag encoding is 0 = int and 1 = float.
- R2: The accumulator read port of slot s shows register s (value and tag) combinationally, for s = 0 and s = 1.
- R3: The operand read port of each slot shows the value and tag of the register chosen by that slot's 3-bit `opnd_sel`, combinationally.
- R4: Op code 0 (accumulator to register) writes the slot's accumulator value and tag into register `opnd_sel` on the next rising edge.
- R5: Op code 1 (register to accumulator) writes the value and tag of register `opnd_sel` into the slot's accumulator.
- R6: Op code 2 (accumulate) writes `result` into the slot's accumulator and leaves the accumulator's existing tag in place.
- R7: Op code 3 (less-than compare) writes `result` into the slot's accumulator with the tag forced to int.
- R8: Op code 4 (load) writes `result` and `result_tag` into register `opnd_sel`.
- R9: Op code 5 (convert) writes `result` into the slot's accumulator with a tag that is the inverse of the operand register's tag.
- R10: A slot whose `wr_en` bit is low, or that carries op code 6 or 7, writes nothing.
- R11: When both slots write the same register in one cycle, the slot-1 write is the one kept, and `same_target` is high combinationally in that cycle.
- R12: All reads in a word use the state from before the edge. Slot 0 copying register 1 while slot 1 copies register 0 therefore exchanges the two accumulators, tags included.
- R13: Slot 0 copying register 0 into its accumulator, paired with slot 1 copying register 1 into its accumulator, leaves every register and tag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 2 | Per-slot write enable (bit s = slot s) |
| op | input | 2x3 | Per-slot decoded operation class |
| opnd_sel | input | 2x3 | Per-slot operand register index |
| result | input | 2x16 | Per-slot externally computed value |
| result_tag | input | 2 | Per-slot tag for load results |
| acc_val | output | 2x16 | Per-slot accumulator value |
| acc_tag | output | 2 | Per-slot accumulator tag |
| opnd_val | output | 2x16 | Per-slot operand register value |
| opnd_tag | output | 2 | Per-slot operand register tag |
| same_target | output | 1 | Both slots write the same register this cycle |

## Verification
The hardest situations to reach from the ports are the ones where two writes interact. One is a word in which both slots hit the same register through different operation classes, for example a slot-0 accumulate against a slot-1 load into register 0. The other is a word whose writes depend on the value the other slot is replacing in that same word. The bench reaches both by sweeping every combination of the two op codes and the two operand selects, 4096 words in all, with enables that vary. After each word it reads all eight registers back through the operand ports and compares them with an arithmetic model. Directed words cover the register exchange and the no-op pair.

// File: rtl/twin_acc_pkg.sv
package twin_acc_pkg;
  typedef enum logic [2:0] {
    OPC_ACC_TO_REG = 3'd0,
    OPC_REG_TO_ACC = 3'd1,
    OPC_ACC_ALU    = 3'd2,
    OPC_ACC_CMP    = 3'd3,
    OPC_REG_LOAD   = 3'd4,
    OPC_ACC_CVT    = 3'd5
  } opc_e;

  localparam logic TAG_INT = 1'b0;
  localparam logic TAG_FLT = 1'b1;
endpackage

// File: rtl/tacc_slot_wb.sv
module tacc_slot_wb
  import twin_acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  parameter int SLOT   = 0
) (
  input  logic              en,
  input  logic [2:0]        op,
  input  logic [IDX_W-1:0]  sel,
  input  logic [DATA_W-1:0] result,
  input  logic              result_tag,
  input  logic [DATA_W-1:0] acc_val,
  input  logic              acc_tag,
  input  logic [DATA_W-1:0] opnd_val,
  input  logic              opnd_tag,
  output logic              we,
  output logic [IDX_W-1:0]  widx,
  output logic [DATA_W-1:0] wval,
  output logic              wtag
);
  localparam logic [IDX_W-1:0] ACC_IDX = IDX_W'(SLOT);

  always_comb begin
    we   = en;
    widx = ACC_IDX;
    wval = result;
    wtag = acc_tag;
    case (opc_e'(op))
      OPC_ACC_TO_REG: begin widx = sel; wval = acc_val; wtag = acc_tag; end
      OPC_REG_TO_ACC: begin wval = opnd_val; wtag = opnd_tag; end
      OPC_ACC_ALU:    wtag = acc_tag;
      OPC_ACC_CMP:    wtag = TAG_INT;
      OPC_REG_LOAD:   begin widx = sel; wtag = result_tag; end
      OPC_ACC_CVT:    wtag = ~opnd_tag;
      default:        we = 1'b0;
    endcase
  end
endmodule

// File: rtl/tacc_reg_store.sv
module tacc_reg_store #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int NUM_WR   = 2,
  parameter int NUM_RD   = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_WR-1:0]              we,
  input  logic [NUM_WR-1:0][IDX_W-1:0]   widx,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  wval,
  input  logic [NUM_WR-1:0]              wtag,
  input  logic [NUM_RD-1:0][IDX_W-1:0]   ridx,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rval,
  output logic [NUM_RD-1:0]              rtag
);
  logic [DATA_W-1:0] val_q [NUM_REGS];
  logic              tag_q [NUM_REGS];

  // Higher-numbered write ports are applied later and therefore win.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        val_q[r] <= '0;
        tag_q[r] <= 1'b0;
      end
    end else begin
      for (int p = 0; p < NUM_WR; p++) begin
        if (we[p]) begin
          val_q[widx[p]] <= wval[p];
          tag_q[widx[p]] <= wtag[p];
        end
      end
    end
  end

  for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
    assign rval[k] = val_q[ridx[k]];
    assign rtag[k] = tag_q[ridx[k]];
  end
endmodule

// File: rtl/twin_acc_regfile.sv
module twin_acc_regfile #(
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 16,
  parameter int NUM_SLOTS = 2,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_SLOTS-1:0]              wr_en,
  input  logic [NUM_SLOTS-1:0][2:0]         op,
  input  logic [NUM_SLOTS-1:0][IDX_W-1:0]   opnd_sel,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0]  result,
  input  logic [NUM_SLOTS-1:0]              result_tag,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]  acc_val,
  output logic [NUM_SLOTS-1:0]              acc_tag,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]  opnd_val,
  output logic [NUM_SLOTS-1:0]              opnd_tag,
  output logic                              same_target
);
  localparam int NUM_RD = 2 * NUM_SLOTS;

  logic [NUM_RD-1:0][IDX_W-1:0]     ridx;
  logic [NUM_RD-1:0][DATA_W-1:0]    rval;
  logic [NUM_RD-1:0]                rtag;
  logic [NUM_SLOTS-1:0]             we;
  logic [NUM_SLOTS-1:0][IDX_W-1:0]  widx;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] wval;
  logic [NUM_SLOTS-1:0]             wtag;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign ridx[s]           = IDX_W'(s);
    assign ridx[NUM_SLOTS+s] = opnd_sel[s];
    assign acc_val[s]  = rval[s];
    assign acc_tag[s]  = rtag[s];
    assign opnd_val[s] = rval[NUM_SLOTS+s];
    assign opnd_tag[s] = rtag[NUM_SLOTS+s];

    tacc_slot_wb #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SLOT(s)) u_wb (
      .en(wr_en[s]), .op(op[s]), .sel(opnd_sel[s]),
      .result(result[s]), .result_tag(result_tag[s]),
      .acc_val(acc_val[s]), .acc_tag(acc_tag[s]),
      .opnd_val(opnd_val[s]), .opnd_tag(opnd_tag[s]),
      .we(we[s]), .widx(widx[s]), .wval(wval[s]), .wtag(wtag[s])
    );
  end

  always_comb begin
    same_target = 1'b0;
    for (int a = 0; a < NUM_SLOTS; a++)
      for (int b = a + 1; b < NUM_SLOTS; b++)
        if (we[a] && we[b] && widx[a] == widx[b]) same_target = 1'b1;
  end

  tacc_reg_store #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_WR(NUM_SLOTS), .NUM_RD(NUM_RD)
  ) u_store (
    .clk(clk), .rst(rst), .we(we), .widx(widx), .wval(wval), .wtag(wtag),
    .ridx(ridx), .rval(rval), .rtag(rtag)
  );
endmodule

// File: rtl/twin_acc_regfile_chk.sv
module twin_acc_regfile_chk
  import twin_acc_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 3
) (
  input logic                             clk,
  input logic                             rst,
  input logic [NUM_SLOTS-1:0]             wr_en,
  input logic [NUM_SLOTS-1:0][2:0]        op,
  input logic [NUM_SLOTS-1:0][DATA_W-1:0] result,
  input logic [NUM_SLOTS-1:0][DATA_W-1:0] acc_val,
  input logic [NUM_SLOTS-1:0]             acc_tag,
  input logic [NUM_SLOTS-1:0][DATA_W-1:0] opnd_val,
  input logic [NUM_SLOTS-1:0]             opnd_tag,
  input logic                             same_target
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
    AST_RESET_CLEARS: assert property (@(posedge clk)
      $past(rst) == 1'b1 |-> acc_val[s] == '0 && acc_tag[s] == TAG_INT); // R1
    AST_COPY_TO_ACC: assert property (@(posedge clk) disable iff (rst)
      wr_en[s] && op[s] == OPC_REG_TO_ACC && !same_target
      |=> acc_val[s] == $past(opnd_val[s]) && acc_tag[s] == $past(opnd_tag[s])); // R5
    AST_ALU_KEEPS_TAG: assert property (@(posedge clk) disable iff (rst)
      wr_en[s] && op[s] == OPC_ACC_ALU && !same_target
      |=> acc_val[s] == $past(result[s]) && acc_tag[s] == $past(acc_tag[s])); // R6
    AST_CMP_GIVES_INT: assert property (@(posedge clk) disable iff (rst)
      wr_en[s] && op[s] == OPC_ACC_CMP && !same_target
      |=> acc_tag[s] == TAG_INT); // R7
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    wr_en == '0 |=> $stable(acc_val) && $stable(acc_tag)); // R10
  AST_COLLIDE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    same_target |-> $countones(wr_en) >= 2); // R11
endmodule

bind twin_acc_regfile twin_acc_regfile_chk #(
  .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .op(op), .result(result),
  .acc_val(acc_val), .acc_tag(acc_tag), .opnd_val(opnd_val),
  .opnd_tag(opnd_tag), .same_target(same_target)
);

// File: tb/twin_acc_regfile_tb_top.sv
module twin_acc_regfile_tb_top;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [1:0]       wr_en = '0;
  logic [1:0][2:0]  op = '0;
  logic [1:0][2:0]  opnd_sel = '0;
  logic [1:0][15:0] result = '0;
  logic [1:0]       result_tag = '0;
  logic [1:0][15:0] acc_val;
  logic [1:0]       acc_tag;
  logic [1:0][15:0] opnd_val;
  logic [1:0]       opnd_tag;
  logic             same_target;

  twin_acc_regfile dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .op(op), .opnd_sel(opnd_sel),
    .result(result), .result_tag(result_tag), .acc_val(acc_val),
    .acc_tag(acc_tag), .opnd_val(opnd_val), .opnd_tag(opnd_tag),
    .same_target(same_target)
  );

  int checks = 0;
  int fails  = 0;
  logic [15:0] m_val [NR];
  logic        m_tag [NR];
  string       m_req [NR];

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string op_req(logic [2:0] o);
    case (o)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Reads all registers through both operand ports (R3) and the accumulators (R2).
  task automatic verify_all();
    for (int k = 0; k < NR / 2; k++) begin
      @(negedge clk);
      wr_en = '0;
      opnd_sel[0] = 3'(2 * k);
      opnd_sel[1] = 3'(2 * k + 1);
      #1;
      for (int s = 0; s < 2; s++) begin
        int r = 2 * k + s;
        check(opnd_val[s] == m_val[r] && opnd_tag[s] == m_tag[r],
              {m_req[r], "/R3"}, $sformatf("reg %0d", r),
              {15'd0, opnd_tag[s], opnd_val[s]}, {15'd0, m_tag[r], m_val[r]});
      end
    end
    check(acc_val[0] == m_val[0] && acc_val[1] == m_val[1] &&
          acc_tag[0] == m_tag[0] && acc_tag[1] == m_tag[1], "R2", "accumulators",
          {acc_val[1], acc_val[0]}, {m_val[1], m_val[0]});
  endtask

  task automatic step(logic [1:0] en, logic [2:0] o0, logic [2:0] o1,
                      logic [2:0] s0, logic [2:0] s1, logic [15:0] r0,
                      logic [15:0] r1, logic g0, logic g1);
    logic        t_we  [2];
    logic [2:0]  t_idx [2];
    logic [15:0] t_val [2];
    logic        t_tag [2];
    logic [2:0]  o [2];
    logic [2:0]  sl [2];
    logic [15:0] rs [2];
    logic        gs [2];
    logic        exp_coll;
    o[0] = o0; o[1] = o1; sl[0] = s0; sl[1] = s1;
    rs[0] = r0; rs[1] = r1; gs[0] = g0; gs[1] = g1;
    @(negedge clk);
    wr_en = en; op[0] = o0; op[1] = o1; opnd_sel[0] = s0; opnd_sel[1] = s1;
    result[0] = r0; result[1] = r1; result_tag[0] = g0; result_tag[1] = g1;
    for (int s = 0; s < 2; s++) begin
      t_we[s] = en[s] && o[s] < 3'd6;
      t_idx[s] = (o[s] == 3'd0 || o[s] == 3'd4) ? sl[s] : 3'(s);
      t_val[s] = rs[s];
      t_tag[s] = m_tag[s];
      case (o[s])
        3'd0: begin t_val[s] = m_val[s]; t_tag[s] = m_tag[s]; end
        3'd1: begin t_val[s] = m_val[sl[s]]; t_tag[s] = m_tag[sl[s]]; end
        3'd3: t_tag[s] = 1'b0;
        3'd4: t_tag[s] = gs[s];
        3'd5: t_tag[s] = ~m_tag[sl[s]];
        default: ;
      endcase
    end
    exp_coll = t_we[0] && t_we[1] && t_idx[0] == t_idx[1];
    #1;
    check(same_target == exp_coll, "R11", "same_target flag", 32'(same_target), 32'(exp_coll));
    @(posedge clk);
    for (int r = 0; r < NR; r++) m_req[r] = "R10";
    for (int s = 0; s < 2; s++) begin
      if (t_we[s]) begin
        m_val[t_idx[s]] = t_val[s];
        m_tag[t_idx[s]] = t_tag[s];
        m_req[t_idx[s]] = (s == 1 && exp_coll) ? "R11" : op_req(o[s]);
      end
    end
    verify_all();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++) begin m_val[r] = '0; m_tag[r] = 1'b0; m_req[r] = "R1"; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    verify_all();

    // Load distinct values into both accumulators (R8).
    step(2'b11, 3'd4, 3'd4, 3'd0, 3'd1, 16'h1234, 16'hBEEF, 1'b1, 1'b0);
    // Exchange through simultaneous copies (R12).
    step(2'b11, 3'd1, 3'd1, 3'd1, 3'd0, 16'h0, 16'h0, 1'b0, 1'b0);
    check(acc_val[0] == 16'hBEEF && acc_tag[0] == 1'b0, "R12", "slot0 after exchange",
          {15'd0, acc_tag[0], acc_val[0]}, 32'h0000BEEF);
    check(acc_val[1] == 16'h1234 && acc_tag[1] == 1'b1, "R12", "slot1 after exchange",
          {15'd0, acc_tag[1], acc_val[1]}, 32'h00011234);
    // No-op pair (R13).
    step(2'b11, 3'd1, 3'd1, 3'd0, 3'd1, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1);
    check(acc_val[0] == 16'hBEEF && acc_val[1] == 16'h1234 && acc_tag == 2'b10, "R13",
          "no-op pair", {acc_tag, acc_val[1][13:0], acc_val[0]}, {2'b10, 14'h1234, 16'hBEEF});
    // Directed collision: slot0 accumulate vs slot1 load into register 0 (R11).
    step(2'b11, 3'd2, 3'd4, 3'd5, 3'd0, 16'h1111, 16'h2222, 1'b0, 1'b1);
    check(acc_val[0] == 16'h2222 && acc_tag[0] == 1'b1, "R11", "slot1 wins",
          {15'd0, acc_tag[0], acc_val[0]}, 32'h00012222);

    // Sweep of every op/select combination for both slots.
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] b;
      logic [1:0]  en;
      b = 12'(i);
      en = (i % 5 == 4) ? 2'(i % 3) : 2'b11;
      step(en, b[2:0], b[5:3], b[8:6], b[11:9],
           16'(i * 40503 + 12345), 16'(i * 9973 + 777), b[0] ^ b[3], b[1] ^ b[6]);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule